// File: doc/BRIEF.md
# Interlaced Video Sync Generator

This block produces the beam timing for a standard-definition interlaced display. It supports both the 625-line and the 525-line television standards. A horizontal slot counter advances on every enabled clock. When the counter passes the last slot of a line, it returns to zero and a line counter advances. When a field ends, the line counter returns to zero and the field parity may change. Fixed positions on this beam grid start and stop six flags: horizontal sync, vertical sync, composite sync, horizontal blank, vertical blank and a vertical equalization window.

Each flag is held in a register. It rises on the enabled clock edge at which the counters sit on the flag's start position, and it falls on the enabled clock edge at which they sit on its end position. So every output changes only on an enabled edge and cannot glitch. The counters and the field parity also leave the block so that a display pipeline can use them. A mode input selects the standard, and a second input turns field alternation on or off. Change both inputs only while reset is held.

Top module: `video_sync_gen`

## Requirements
- R1: While reset is held, and on the first cycle after it, both counters read 0, `field_odd` reads 1 and every sync, blank and window output reads 0.
- R2: The counters and all outputs change only on clock edges where `ce` is 1. In the 625-line mode (`pal_mode`=1), `h_pos` counts 0..227 and then returns to 0, so every line has 228 slots.
- R3: In the 525-line mode (`pal_mode`=0), line lengths alternate between 228 slots (last slot 227) and 227 slots (last slot 226). The first line after reset has 228 slots.
- R4: A field has LONG+1 lines when `field_odd`=1 and LONG lines when `field_odd`=0. LONG is the parameter `VLAST_PAL_LONG` or `VLAST_NTSC_LONG` for the current mode. With `interlace_en`=1, parity flips at every field wrap. With `interlace_en`=0, every field is odd.
- R5: `hblank` and `hsync` rise after the enabled edge at slot 18 and fall after the enabled edge at slot 35, on every line, in every field and in both modes.
- R6: `vblank` rises after the enabled edge at (last line of the field, slot 1). It falls after the enabled edge at (line 25, slot 1) in the 625-line mode and at (line 20, slot 1) in the 525-line mode.
- R7: In the 625-line mode, the odd field's `vsync` spans from (line 2, slot 132) to (line 5, slot 18). The even field's `vsync` spans from (line 3, slot 18) to (line 5, slot 132).
- R8: In the 525-line mode, `vsync` spans from line 3 to line 6. Both of its edges fall at slot 18 in the odd field and at slot 132 in the even field.
- R9: In the 625-line mode, `equ_win` spans from (0, 9) to (7, 115) in the odd field and from (0, 115) to (8, 9) in the even field. In the 525-line mode, it spans from line 0 to line 9, with both edges at slot 9 (odd field) or at slot 115 (even field).
- R10: `csync` equals `hsync` ORed with two pulses that count only while `vsync` is 1. The first pulse spans slots 18 to 26 (625-line mode) or 18 to 27 (525-line mode). The second pulse spans slots 132 to 140 or 132 to 141 respectively. Its register takes the same update edge as the other flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce | input | 1 | Slot advance enable |
| pal_mode | input | 1 | 1: 625-line timing, 0: 525-line timing |
| interlace_en | input | 1 | 1: field parity alternates |
| h_pos | output | 8 | Horizontal slot counter |
| v_pos | output | 9 | Line counter within the field |
| field_odd | output | 1 | 1 during an odd (long) field |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| csync | output | 1 | Composite sync, active high |
| hblank | output | 1 | Horizontal blank |
| vblank | output | 1 | Vertical blank |
| equ_win | output | 1 | Vertical equalization window |

## Verification
Several edges land on the same enabled edge. In the odd 525-line field, the rise of `vsync` at slot 18 coincides with the rise of `hsync` and of the first composite pulse. The field wrap always coincides with a line wrap and with the toggle of the 525-line line length. The bench drives complete fields in both modes, with and without field alternation, and with gaps in `ce`. A cycle-level reference model fills a scoreboard that is compared against every output on every cycle. Separate counts of line and field lengths check the wrap points in every field.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  localparam int HW = 8;
  localparam int VW = 9;
  localparam int NFLAG = 7;

  localparam int F_HBLANK  = 0;
  localparam int F_HSYNC   = 1;
  localparam int F_VSYNC   = 2;
  localparam int F_VBLANK  = 3;
  localparam int F_EQU     = 4;
  localparam int F_PULSE_A = 5;
  localparam int F_PULSE_B = 6;

  typedef logic [HW-1:0] hpos_t;
  typedef logic [VW-1:0] vpos_t;

  // A beam position; every_line ignores the line number
  typedef struct packed {
    logic  every_line;
    hpos_t h;
    vpos_t v;
  } mark_t;

  function automatic mark_t mark(logic every, int unsigned h, int unsigned v);
    mark_t m;
    m.every_line = every;
    m.h = hpos_t'(h);
    m.v = vpos_t'(v);
    return m;
  endfunction

  function automatic hpos_t line_last(logic pal, logic long_ln);
    return (pal || long_ln) ? hpos_t'(227) : hpos_t'(226);
  endfunction

  function automatic vpos_t field_last(logic pal, logic odd, vpos_t pal_long, vpos_t ntsc_long);
    vpos_t base;
    base = pal ? pal_long : ntsc_long;
    return odd ? base : base - vpos_t'(1);
  endfunction

  function automatic mark_t flag_start(int idx, logic pal, logic odd, vpos_t vlast);
    mark_t m;
    m = mark(1'b1, 18, 0);
    case (idx)
      F_VSYNC:   m = pal ? (odd ? mark(1'b0, 132, 2) : mark(1'b0, 18, 3))
                         : (odd ? mark(1'b0, 18, 3)  : mark(1'b0, 132, 3));
      F_VBLANK:  begin m = mark(1'b0, 1, 0); m.v = vlast; end
      F_EQU:     m = odd ? mark(1'b0, 9, 0) : mark(1'b0, 115, 0);
      F_PULSE_B: m = mark(1'b1, 132, 0);
      default:   m = mark(1'b1, 18, 0);
    endcase
    return m;
  endfunction

  function automatic mark_t flag_end(int idx, logic pal, logic odd);
    mark_t m;
    m = mark(1'b1, 35, 0);
    case (idx)
      F_VSYNC:   m = pal ? (odd ? mark(1'b0, 18, 5) : mark(1'b0, 132, 5))
                         : (odd ? mark(1'b0, 18, 6) : mark(1'b0, 132, 6));
      F_VBLANK:  m = mark(1'b0, 1, pal ? 25 : 20);
      F_EQU:     m = pal ? (odd ? mark(1'b0, 115, 7) : mark(1'b0, 9, 8))
                         : (odd ? mark(1'b0, 9, 9)   : mark(1'b0, 115, 9));
      F_PULSE_A: m = mark(1'b1, pal ? 26 : 27, 0);
      F_PULSE_B: m = mark(1'b1, pal ? 140 : 141, 0);
      default:   m = mark(1'b1, 35, 0);
    endcase
    return m;
  endfunction

  function automatic logic at_mark(mark_t m, hpos_t h, vpos_t v);
    return (h == m.h) && (m.every_line || (v == m.v));
  endfunction
endpackage

// File: rtl/vsg_beam_counter.sv
module vsg_beam_counter
  import vsg_pkg::*;
#(
  parameter int VLAST_PAL_LONG  = 312,
  parameter int VLAST_NTSC_LONG = 262
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ce,
  input  logic  pal,
  input  logic  interlace,
  output hpos_t h_pos,
  output vpos_t v_pos,
  output logic  field_odd,
  output logic  line_end,
  output logic  field_end,
  output vpos_t vlast
);
  localparam vpos_t PAL_LONG  = vpos_t'(VLAST_PAL_LONG);
  localparam vpos_t NTSC_LONG = vpos_t'(VLAST_NTSC_LONG);

  logic long_line;

  assign vlast     = field_last(pal, field_odd, PAL_LONG, NTSC_LONG);
  assign line_end  = (h_pos >= line_last(pal, long_line));
  assign field_end = line_end && (v_pos >= vlast);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_pos     <= '0;
      v_pos     <= '0;
      field_odd <= 1'b1;
      long_line <= 1'b1;
    end else if (ce) begin
      if (line_end) begin
        h_pos     <= '0;
        long_line <= pal ? 1'b1 : ~long_line;
        if (field_end) begin
          v_pos     <= '0;
          field_odd <= interlace ? ~field_odd : 1'b1;
        end else begin
          v_pos <= v_pos + vpos_t'(1);
        end
      end else begin
        h_pos <= h_pos + hpos_t'(1);
      end
    end
  end
endmodule

// File: rtl/vsg_decoder.sv
module vsg_decoder
  import vsg_pkg::*;
(
  input  hpos_t            h_pos,
  input  vpos_t            v_pos,
  input  logic             pal,
  input  logic             odd,
  input  vpos_t            vlast,
  output logic [NFLAG-1:0] set_hit,
  output logic [NFLAG-1:0] clr_hit
);
  for (genvar g = 0; g < NFLAG; g++) begin : g_mark
    mark_t start_m;
    mark_t end_m;
    assign start_m    = flag_start(g, pal, odd, vlast);
    assign end_m      = flag_end(g, pal, odd);
    assign set_hit[g] = at_mark(start_m, h_pos, v_pos);
    assign clr_hit[g] = at_mark(end_m, h_pos, v_pos);
  end
endmodule

// File: rtl/vsg_flag.sv
module vsg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic set_hit,
  input  logic clr_hit,
  output logic q,
  output logic q_next
);
  always_comb begin
    q_next = q;
    if (ce) begin
      if (set_hit)      q_next = 1'b1;
      else if (clr_hit) q_next = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_next;
  end
endmodule

// File: rtl/video_sync_gen.sv
module video_sync_gen
  import vsg_pkg::*;
#(
  parameter int VLAST_PAL_LONG  = 312,
  parameter int VLAST_NTSC_LONG = 262
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          pal_mode,
  input  logic          interlace_en,
  output logic [HW-1:0] h_pos,
  output logic [VW-1:0] v_pos,
  output logic          field_odd,
  output logic          hsync,
  output logic          vsync,
  output logic          csync,
  output logic          hblank,
  output logic          vblank,
  output logic          equ_win
);
  logic             line_end;
  logic             field_end;
  vpos_t            vlast;
  logic [NFLAG-1:0] set_hit;
  logic [NFLAG-1:0] clr_hit;
  logic [NFLAG-1:0] flag_q;
  logic [NFLAG-1:0] flag_d;
  logic             csync_q;

  vsg_beam_counter #(
    .VLAST_PAL_LONG (VLAST_PAL_LONG),
    .VLAST_NTSC_LONG(VLAST_NTSC_LONG)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce       (ce),
    .pal      (pal_mode),
    .interlace(interlace_en),
    .h_pos    (h_pos),
    .v_pos    (v_pos),
    .field_odd(field_odd),
    .line_end (line_end),
    .field_end(field_end),
    .vlast    (vlast)
  );

  vsg_decoder u_dec (
    .h_pos  (h_pos),
    .v_pos  (v_pos),
    .pal    (pal_mode),
    .odd    (field_odd),
    .vlast  (vlast),
    .set_hit(set_hit),
    .clr_hit(clr_hit)
  );

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    vsg_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .ce     (ce),
      .set_hit(set_hit[g]),
      .clr_hit(clr_hit[g]),
      .q      (flag_q[g]),
      .q_next (flag_d[g])
    );
  end

  // Composite sync built from the next-state flags so it lines up with them
  always_ff @(posedge clk) begin
    if (!rst_n) csync_q <= 1'b0;
    else csync_q <= flag_d[F_HSYNC] |
                    (flag_d[F_VSYNC] & (flag_d[F_PULSE_A] | flag_d[F_PULSE_B]));
  end

  assign hblank  = flag_q[F_HBLANK];
  assign hsync   = flag_q[F_HSYNC];
  assign vsync   = flag_q[F_VSYNC];
  assign vblank  = flag_q[F_VBLANK];
  assign equ_win = flag_q[F_EQU];
  assign csync   = csync_q;
endmodule

// File: rtl/vsg_checker.sv
module vsg_checker #(
  parameter int VLAST_PAL_LONG  = 312,
  parameter int VLAST_NTSC_LONG = 262
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ce,
  input logic       pal,
  input logic [7:0] h_pos,
  input logic [8:0] v_pos,
  input logic       field_odd,
  input logic       line_end,
  input logic       field_end,
  input logic       hsync,
  input logic       hblank,
  input logic       vsync,
  input logic       csync,
  input logic       equ
);
  assert_hpos_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    h_pos <= 8'd227) else $error("h_pos beyond last slot");

  assert_line_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && line_end) |=> (h_pos == 8'd0)) else $error("line wrap missed");

  assert_hold_without_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(h_pos) && $stable(v_pos) && $stable(hsync) && $stable(vsync) &&
             $stable(csync) && $stable(equ))) else $error("state moved without ce");

  assert_vpos_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(v_pos) <= (pal ? VLAST_PAL_LONG : VLAST_NTSC_LONG)) else $error("v_pos beyond field");

  assert_parity_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ce && field_end) |=> $stable(field_odd)) else $error("parity moved mid-field");

  assert_hsync_hblank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hsync == hblank) else $error("hsync and hblank disagree");

  assert_vsync_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && pal) |-> (v_pos >= 9'd2 && v_pos <= 9'd5)) else $error("vsync outside lines");

  assert_vsync_lines_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && !pal) |-> (v_pos >= 9'd3 && v_pos <= 9'd6)) else $error("vsync outside lines");

  assert_equ_lines_R9: assert property (@(posedge clk) disable iff (!rst_n)
    equ |-> (v_pos <= 9'd9)) else $error("equalization outside top lines");

  assert_csync_has_hsync_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |-> csync) else $error("csync lost hsync");

  assert_csync_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync && !vsync) |-> !csync) else $error("csync pulse without vsync");
endmodule

bind video_sync_gen vsg_checker #(
  .VLAST_PAL_LONG (VLAST_PAL_LONG),
  .VLAST_NTSC_LONG(VLAST_NTSC_LONG)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce       (ce),
  .pal      (pal_mode),
  .h_pos    (h_pos),
  .v_pos    (v_pos),
  .field_odd(field_odd),
  .line_end (line_end),
  .field_end(field_end),
  .hsync    (hsync),
  .hblank   (hblank),
  .vsync    (vsync),
  .csync    (csync),
  .equ      (equ_win)
);

// File: tb/video_sync_gen_tb.sv
module video_sync_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PL = 60;  // long-field last line, 625-line mode (shortened)
  localparam int NL = 50;  // long-field last line, 525-line mode (shortened)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0;
  logic pal = 1'b1;
  logic il = 1'b1;
  logic [7:0] h_pos;
  logic [8:0] v_pos;
  logic field_odd, hsync, vsync, csync, hblank, vblank, equ_win;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  video_sync_gen #(.VLAST_PAL_LONG(PL), .VLAST_NTSC_LONG(NL)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .pal_mode(pal), .interlace_en(il),
    .h_pos(h_pos), .v_pos(v_pos), .field_odd(field_odd), .hsync(hsync),
    .vsync(vsync), .csync(csync), .hblank(hblank), .vblank(vblank), .equ_win(equ_win)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  typedef struct {
    int h; int v; bit odd; bit hb; bit hs; bit vs; bit vb; bit eq; bit cs; bit pal;
  } exp_t;
  exp_t sb[$];

  // Reference model (driver side): pushes the expected post-edge state
  int  m_h, m_v, m_fields, t_last, t_len, t_sv, t_sh, t_ev, t_eh;
  bit  m_odd, m_long, m_hb, m_hs, m_vs, m_vb, m_eq, m_pa, m_pb, m_cs;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_h = 0; m_v = 0; m_odd = 1; m_long = 1; m_fields = 0;
      {m_hb, m_hs, m_vs, m_vb, m_eq, m_pa, m_pb, m_cs} = '0;
    end else begin
      if (ce) begin
        t_last = (pal ? PL : NL) - (m_odd ? 0 : 1);
        if (m_h == 18) begin m_hs = 1; m_hb = 1; m_pa = 1; end
        else if (m_h == 35) begin m_hs = 0; m_hb = 0; end
        if (m_h == (pal ? 26 : 27)) m_pa = 0;
        if (m_h == 132) m_pb = 1;
        else if (m_h == (pal ? 140 : 141)) m_pb = 0;
        if (pal) begin
          t_sv = m_odd ? 2 : 3; t_sh = m_odd ? 132 : 18; t_ev = 5; t_eh = m_odd ? 18 : 132;
        end else begin
          t_sv = 3; t_ev = 6; t_sh = m_odd ? 18 : 132; t_eh = t_sh;
        end
        if (m_v == t_sv && m_h == t_sh) m_vs = 1;
        else if (m_v == t_ev && m_h == t_eh) m_vs = 0;
        if (m_v == t_last && m_h == 1) m_vb = 1;
        else if (m_v == (pal ? 25 : 20) && m_h == 1) m_vb = 0;
        if (m_v == 0 && m_h == (m_odd ? 9 : 115)) m_eq = 1;
        else if (pal && m_odd && m_v == 7 && m_h == 115) m_eq = 0;
        else if (pal && !m_odd && m_v == 8 && m_h == 9) m_eq = 0;
        else if (!pal && m_v == 9 && m_h == (m_odd ? 9 : 115)) m_eq = 0;
        m_cs = m_hs | (m_vs & (m_pa | m_pb));
        t_len = (pal || m_long) ? 228 : 227;
        if (m_h == t_len - 1) begin
          m_h = 0;
          if (!pal) m_long = !m_long;
          if (m_v == t_last) begin
            m_v = 0; m_odd = il ? !m_odd : 1'b1; m_fields++;
          end else m_v++;
        end else m_h++;
      end
      sb.push_back('{m_h, m_v, m_odd, m_hb, m_hs, m_vs, m_vb, m_eq, m_cs, pal});
    end
  end

  // Monitor: pops one expectation per cycle and compares away from the edge
  int p_h = 0, p_v = 0, last_len = 227;
  bit p_odd = 1;
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(int'(h_pos) == e.h, e.pal ? "R2" : "R3", "h_pos", int'(h_pos), e.h);
      check(int'(v_pos) == e.v, "R4", "v_pos", int'(v_pos), e.v);
      check(field_odd == e.odd, "R4", "field_odd", field_odd, e.odd);
      check(hblank == e.hb, "R5", "hblank", hblank, e.hb);
      check(hsync == e.hs, "R5", "hsync", hsync, e.hs);
      check(vsync == e.vs, e.pal ? "R7" : "R8", "vsync", vsync, e.vs);
      check(vblank == e.vb, "R6", "vblank", vblank, e.vb);
      check(equ_win == e.eq, "R9", "equ_win", equ_win, e.eq);
      check(csync == e.cs, "R10", "csync", csync, e.cs);
      if (h_pos == 8'd0 && p_h != 0) begin
        if (pal) check(p_h + 1 == 228, "R2", "line length", p_h + 1, 228);
        else begin
          check(p_h + 1 != last_len && p_h >= 226, "R3", "line length",
                p_h + 1, (last_len == 228) ? 227 : 228);
          last_len = p_h + 1;
        end
      end
      if (v_pos == 9'd0 && p_v != 0)
        check(p_v + 1 == (pal ? PL : NL) + (p_odd ? 1 : 0), "R4", "field lines",
              p_v + 1, (pal ? PL : NL) + (p_odd ? 1 : 0));
    end
    if (!rst_n) begin
      p_h = 0; p_v = 0; p_odd = 1; last_len = 227;
    end else begin
      p_h = int'(h_pos); p_v = int'(v_pos); p_odd = field_odd;
    end
  end

  task automatic run_phase(bit mode_pal, bit mode_il, bit gaps);
    int cyc;
    @(negedge clk);
    rst_n = 0; ce = 0; pal = mode_pal; il = mode_il;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(h_pos == 0 && v_pos == 0, "R1", "counters", int'(h_pos) + int'(v_pos), 0);
    check(field_odd == 1'b1, "R1", "field_odd", field_odd, 1);
    check({hsync, vsync, csync, hblank, vblank, equ_win} == '0, "R1", "outputs",
          int'({hsync, vsync, csync, hblank, vblank, equ_win}), 0);
    rst_n = 1;
    @(negedge clk);
    check(h_pos == 0 && {hsync, vblank} == '0, "R1", "first cycle", int'(h_pos), 0);
    cyc = 0;
    while (m_fields < 2) begin
      ce = gaps ? (cyc % 4 != 3) : 1'b1;
      cyc++;
      @(negedge clk);
    end
    ce = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    run_phase(1'b1, 1'b1, 1'b1);
    run_phase(1'b0, 1'b1, 1'b0);
    run_phase(1'b0, 1'b0, 1'b1);
    run_phase(1'b1, 1'b0, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 190000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule